// File: doc/BRIEF.md
# Display Control Command Decoder

This block sits on the control side of a display controller. Each 32-bit write to its control port carries a command code in bits 31:24 and parameters in the bits below. The decoder updates a 32-bit status word and the display geometry from these writes. The geometry is the start position of the shown area, the horizontal and vertical capture ranges, and the selected mode resolution. From the geometry it derives the visible width and height. It also answers information queries by loading a read-data latch from a small bank of drawing settings. The neighbouring drawing logic writes that bank through a separate load port.

The visible height comes from combinational arithmetic on the new register values, so it is registered at the same edge as the write. The visible width needs a scale of the horizontal span by the mode width over 2560. A restoring divider works this out over several cycles, and a valid flag is low while it runs. A write whose data matches the copy already held for its command code, in the first sixteen codes, is filtered out. The reset command and the display-start command are exempt from that filter.

Top module: `dispctl_decoder`

## Requirements
- R1: After hardware reset, and after every accepted command 0x00, the status word is 0x14802000 and the read latch is 0. Mode width and visible width are 256, mode height and visible height are 240, and width valid is 1. A 0x00 write whose data equals the held copy is still accepted.
- R2: Command 0x03 copies data bit 0 into status bit 23 (blanking). Command 0x04 copies data bits 1:0 into status bits 30:29 (transfer direction). Neither changes any other status bit.
- R3: Command 0x05 sets display start X to data[9:0] and start Y to data[19:10].
- R4: Command 0x06 loads X1 from data[11:0] and X2 from data[23:12]. When the span S=X2−X1 lies in 1..2559, width valid drops and then rises with width = floor(S×modewidth/2560). Otherwise the width equals the mode width and is valid in the cycle after the write.
- R5: Command 0x07 loads Y1 from data[9:0] and Y2 from data[19:10]. The height is Y2−Y1, doubled when status bit 19 is set, and becomes the mode height when that result is ≤0. The height is updated in the cycle after the write.
- R6: Command 0x08 writes data[5:0] to status[22:17] and data[6] to status[16]. The mode width comes from a parameter table indexed by status[18:16]; the default table is 256,368,320,384,512,512,640,640 for indexes 0..7. The mode height comes from status[20:19] through the table 240,480,256,480. Both visible sizes are recomputed.
- R7: Commands 0x10..0x1F are queries on data[3:0]. Indexes 2..5 load the read latch with drawing setting [index] (20 bits, zero-extended). Index 6 loads setting 5, index 7 loads the value 2, and any other index loads 0.
- R8: A write of command 1..4 or 6..15 whose data equals the held copy for that code is ignored. Such a write does not restart the width calculation.
- R9: A query in the same cycle as a settings load to the same index returns the value held before the load.
- R10: A write of command 0x06 or 0x08 while a width calculation is running restarts it, and the final width reflects the latest write.
- R11: Commands without a function (such as 0x09 or 0x20) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 32 | Control word: command in 31:24, parameters below |
| set_we | input | 1 | Drawing setting load strobe |
| set_idx | input | 3 | Drawing setting index |
| set_data | input | 20 | Drawing setting value |
| status_o | output | 32 | Status word |
| rd_data_o | output | 32 | Query read latch |
| start_x_o | output | 10 | Display start X |
| start_y_o | output | 10 | Display start Y |
| hres_o | output | 10 | Mode width |
| vres_o | output | 9 | Mode height |
| width_o | output | 10 | Visible width |
| height_o | output | 11 | Visible height |
| width_valid_o | output | 1 | Visible width is current |

## Verification
Two pairs of functions can fall in the same cycle. The first is a settings load and a query naming the same index. The bench drives both strobes on one edge and expects the old value, then queries again and expects the new one. The second is a width calculation still running when a new horizontal range arrives. The bench sends a second range two cycles after the first and requires that the only width reported once valid returns is the one for the later range.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam logic [7:0] OP_RESET  = 8'h00;
  localparam logic [7:0] OP_BLANK  = 8'h03;
  localparam logic [7:0] OP_DMA    = 8'h04;
  localparam logic [7:0] OP_ORIGIN = 8'h05;
  localparam logic [7:0] OP_HSPAN  = 8'h06;
  localparam logic [7:0] OP_VSPAN  = 8'h07;
  localparam logic [7:0] OP_MODE   = 8'h08;
  localparam logic [3:0] OP_QUERY_GRP = 4'h1;

  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;
  localparam int BLANK_BIT = 23;
  localparam int DBL_BIT   = 19;

  localparam int SPAN_W   = 12;
  localparam int POS_W    = 10;
  localparam int HEIGHT_W = 11;
  localparam int VRES_W   = 9;
  localparam logic [SPAN_W-1:0] SPAN_FULL = 12'd2560;

  // signed horizontal span, one extra bit for the sign
  function automatic logic [SPAN_W:0] span_of(input logic [SPAN_W-1:0] lo,
                                               input logic [SPAN_W-1:0] hi);
    return {1'b0, hi} - {1'b0, lo};
  endfunction

  // span outside 1..SPAN_FULL-1 means the whole mode width is shown
  function automatic logic span_is_full(input logic [SPAN_W:0] s);
    return s[SPAN_W] || (s == '0) || (s[SPAN_W-1:0] >= SPAN_FULL);
  endfunction

  function automatic logic [VRES_W-1:0] vres_of(input logic [1:0] idx);
    case (idx)
      2'd0:    return 9'd240;
      2'd2:    return 9'd256;
      default: return 9'd480;
    endcase
  endfunction

  function automatic logic [HEIGHT_W-1:0] height_of(input logic [POS_W-1:0] top,
                                                    input logic [POS_W-1:0] bot,
                                                    input logic dbl,
                                                    input logic [VRES_W-1:0] vres);
    logic [POS_W+1:0] d;
    d = {2'b00, bot} - {2'b00, top};
    if (dbl) d = {d[POS_W:0], 1'b0};
    if (d[POS_W+1] || d == '0) return HEIGHT_W'(vres);
    return d[HEIGHT_W-1:0];
  endfunction
endpackage

// File: rtl/dcd_shadow.sv
module dcd_shadow #(
  parameter int N_REGS = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clear,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  output logic              dup
);
  logic [N_REGS-1:0][DATA_W-1:0] copy_q;

  assign dup = (copy_q[idx] == data);

  for (genvar g = 0; g < N_REGS; g++) begin : g_copy
    localparam logic [DATA_W-1:0] INIT = (g == 3) ? DATA_W'(1) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                          copy_q[g] <= INIT;
      else if (wr_en && idx == IDX_W'(g))           copy_q[g] <= data;
    end
  end
endmodule

// File: rtl/dcd_divider.sv
module dcd_divider #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 12,
  parameter int Q_W   = 10,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             busy_o,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial  = {rem_q, quo_q[NUM_W-1]};
  assign fits   = trial >= {1'b0, den_q};
  assign quot_o = quo_q[Q_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort) begin
        busy_o <= 1'b0;
      end else if (start) begin
        busy_o <= 1'b1;
        rem_q  <= '0;
        den_q  <= divisor;
        quo_q  <= dividend;
        cnt_q  <= CNT_W'(NUM_W);
      end else if (busy_o) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R4
endmodule

// File: rtl/dcd_info.sv
module dcd_info #(
  parameter int N_SET = 8,
  parameter int SET_W = 20,
  localparam int SIDX_W = $clog2(N_SET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [SIDX_W-1:0] load_idx,
  input  logic [SET_W-1:0]  load_val,
  input  logic [3:0]        q_sel,
  output logic [31:0]       answer
);
  logic [N_SET-1:0][SET_W-1:0] bank_q;

  for (genvar g = 0; g < N_SET; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                     bank_q[g] <= '0;
      else if (load_en && load_idx == SIDX_W'(g))     bank_q[g] <= load_val;
    end
  end

  // reads the value held before any load in this cycle (R9)
  always_comb begin
    case (q_sel)
      4'd2, 4'd3, 4'd4, 4'd5: answer = 32'(bank_q[SIDX_W'(q_sel)]);
      4'd6:                   answer = 32'(bank_q[5]);
      4'd7:                   answer = 32'd2;
      default:                answer = '0;
    endcase
  end
endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
  import dcd_pkg::*;
#(
  parameter int HRES_W = 10,
  parameter logic [8*HRES_W-1:0] HRES_TABLE = {10'd640, 10'd640, 10'd512, 10'd512,
                                               10'd384, 10'd320, 10'd368, 10'd256},
  parameter int N_SHADOW = 16,
  parameter int N_SET    = 8,
  parameter int SET_W    = 20,
  localparam int SIDX_W  = $clog2(N_SET),
  localparam int NUM_W   = SPAN_W + HRES_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [31:0]         ctl_data,
  input  logic                set_we,
  input  logic [SIDX_W-1:0]   set_idx,
  input  logic [SET_W-1:0]    set_data,
  output logic [31:0]         status_o,
  output logic [31:0]         rd_data_o,
  output logic [POS_W-1:0]    start_x_o,
  output logic [POS_W-1:0]    start_y_o,
  output logic [HRES_W-1:0]   hres_o,
  output logic [VRES_W-1:0]   vres_o,
  output logic [HRES_W-1:0]   width_o,
  output logic [HEIGHT_W-1:0] height_o,
  output logic                width_valid_o
);
  function automatic logic [HRES_W-1:0] hres_pick(input logic [2:0] i);
    return HRES_TABLE[i*HRES_W +: HRES_W];
  endfunction

  logic [7:0] cmd;
  logic in_bank, dup_w, ignored_w, take_w;
  logic op_reset_w, op_blank_w, op_dma_w, op_origin_w, op_hspan_w, op_vspan_w, op_mode_w, query_w;

  assign cmd       = ctl_data[31:24];
  assign in_bank   = (cmd < 8'(N_SHADOW));
  assign ignored_w = ctl_we && in_bank && cmd != OP_RESET && cmd != OP_ORIGIN && dup_w;
  assign take_w    = ctl_we && !ignored_w;

  assign op_reset_w  = take_w && cmd == OP_RESET;
  assign op_blank_w  = take_w && cmd == OP_BLANK;
  assign op_dma_w    = take_w && cmd == OP_DMA;
  assign op_origin_w = take_w && cmd == OP_ORIGIN;
  assign op_hspan_w  = take_w && cmd == OP_HSPAN;
  assign op_vspan_w  = take_w && cmd == OP_VSPAN;
  assign op_mode_w   = take_w && cmd == OP_MODE;
  assign query_w     = take_w && cmd[7:4] == OP_QUERY_GRP;

  dcd_shadow #(.N_REGS(N_SHADOW), .DATA_W(32)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we && in_bank), .clear(op_reset_w),
    .idx(cmd[$clog2(N_SHADOW)-1:0]), .data(ctl_data), .dup(dup_w));

  logic [31:0] answer_w;
  dcd_info #(.N_SET(N_SET), .SET_W(SET_W)) u_info (
    .clk(clk), .rst_n(rst_n), .load_en(set_we), .load_idx(set_idx), .load_val(set_data),
    .q_sel(ctl_data[3:0]), .answer(answer_w));

  // geometry registers
  logic [SPAN_W-1:0] x1_q, x2_q, x1_n, x2_n;
  logic [POS_W-1:0]  y1_q, y2_q, y1_n, y2_n;
  logic [31:0]       st_n;
  logic [HRES_W-1:0] hres_n;
  logic [VRES_W-1:0] vres_n;
  logic [SPAN_W:0]   span_n;
  logic              width_upd_w, full_w, div_start_w, div_abort_w, div_done_w, div_busy_w;
  logic [HRES_W-1:0] quot_w;
  logic [NUM_W-1:0]  dividend_w;

  always_comb begin
    st_n   = status_o;
    x1_n   = x1_q;
    x2_n   = x2_q;
    y1_n   = y1_q;
    y2_n   = y2_q;
    hres_n = hres_o;
    vres_n = vres_o;
    if (op_reset_w) begin
      st_n   = STATUS_INIT;
      hres_n = HRES_W'(256);
      vres_n = VRES_W'(240);
    end
    if (op_blank_w) st_n[BLANK_BIT] = ctl_data[0];
    if (op_dma_w)   st_n[30:29]     = ctl_data[1:0];
    if (op_hspan_w) begin
      x1_n = ctl_data[11:0];
      x2_n = ctl_data[23:12];
    end
    if (op_vspan_w) begin
      y1_n = ctl_data[9:0];
      y2_n = ctl_data[19:10];
    end
    if (op_mode_w) begin
      st_n[22:16] = {ctl_data[5:0], ctl_data[6]};
      hres_n      = hres_pick({ctl_data[1:0], ctl_data[6]});
      vres_n      = vres_of({ctl_data[3], ctl_data[2]});
    end
  end

  assign span_n      = span_of(x1_n, x2_n);
  assign full_w      = span_is_full(span_n);
  assign width_upd_w = op_hspan_w || op_mode_w;
  assign div_start_w = width_upd_w && !full_w;
  assign div_abort_w = op_reset_w || (width_upd_w && full_w);
  assign dividend_w  = NUM_W'(span_n[SPAN_W-1:0]) * NUM_W'(hres_n);

  dcd_divider #(.NUM_W(NUM_W), .DEN_W(SPAN_W), .Q_W(HRES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start_w), .abort(div_abort_w),
    .dividend(dividend_w), .divisor(SPAN_FULL),
    .busy_o(div_busy_w), .done_o(div_done_w), .quot_o(quot_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o      <= STATUS_INIT;
      rd_data_o     <= '0;
      start_x_o     <= '0;
      start_y_o     <= '0;
      x1_q          <= '0;
      x2_q          <= '0;
      y1_q          <= '0;
      y2_q          <= '0;
      hres_o        <= HRES_W'(256);
      vres_o        <= VRES_W'(240);
      width_o       <= HRES_W'(256);
      height_o      <= HEIGHT_W'(240);
      width_valid_o <= 1'b1;
    end else begin
      status_o <= st_n;
      x1_q     <= x1_n;
      x2_q     <= x2_n;
      y1_q     <= y1_n;
      y2_q     <= y2_n;
      hres_o   <= hres_n;
      vres_o   <= vres_n;
      if (op_reset_w)   rd_data_o <= '0;
      else if (query_w) rd_data_o <= answer_w;
      if (op_origin_w) begin
        start_x_o <= ctl_data[9:0];
        start_y_o <= ctl_data[19:10];
      end
      if (op_reset_w)                    height_o <= HEIGHT_W'(240);
      else if (op_vspan_w || op_mode_w)  height_o <= height_of(y1_n, y2_n, st_n[DBL_BIT], vres_n);
      if (op_reset_w) begin
        width_o       <= HRES_W'(256);
        width_valid_o <= 1'b1;
      end else if (width_upd_w) begin
        if (full_w) width_o <= hres_n;
        width_valid_o <= full_w;
      end else if (div_done_w) begin
        width_o       <= quot_w;
        width_valid_o <= 1'b1;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    op_reset_w |=> status_o == STATUS_INIT && rd_data_o == '0 && width_valid_o
                   && width_o == HRES_W'(256) && height_o == HEIGHT_W'(240)); // R1
  AST_DMA_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_dma_w |=> status_o[30:29] == $past(ctl_data[1:0])); // R2
  AST_ORIGIN_X: assert property (@(posedge clk) disable iff (!rst_n)
    op_origin_w |=> start_x_o == $past(ctl_data[9:0])); // R3
  AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    width_valid_o |-> width_o <= hres_o); // R4
  AST_HEIGHT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    height_o != '0); // R5
  AST_QUERY_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (query_w && ctl_data[3:0] == 4'd7) |=> rd_data_o == 32'd2); // R7
  AST_DUP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored_w && width_valid_o) |=> width_valid_o); // R8
  AST_RESTART_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    div_start_w |=> !width_valid_o && div_busy_w); // R10
endmodule

// File: tb/dispctl_decoder_tb_top.sv
`timescale 1ns/1ps
module dispctl_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_data = '0;
  logic set_we = 1'b0;
  logic [2:0] set_idx = '0;
  logic [19:0] set_data = '0;
  logic [31:0] status_o, rd_data_o;
  logic [9:0] start_x_o, start_y_o, hres_o, width_o;
  logic [8:0] vres_o;
  logic [10:0] height_o;
  logic width_valid_o;

  always #2 clk = ~clk;

  dispctl_decoder dut_i (.*);

  typedef struct { string req; int sel; logic [31:0] val; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  function automatic logic [31:0] out_of(int sel);
    case (sel)
      0: return status_o;
      1: return rd_data_o;
      2: return 32'(start_x_o);
      3: return 32'(start_y_o);
      4: return 32'(width_o);
      5: return 32'(height_o);
      6: return 32'(hres_o);
      7: return 32'(vres_o);
      default: return 32'(width_valid_o);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out_of(e.sel) !== e.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, out_of(e.sel), e.val);
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [31:0] v);
    sb.push_back('{req, sel, v});
  endtask

  task automatic ctl(logic [31:0] d, bit sw = 0, logic [2:0] si = 0, logic [19:0] sd = 0);
    @(negedge clk);
    ctl_data = d; ctl_we = 1'b1;
    set_we = sw; set_idx = si; set_data = sd;
    @(posedge clk); #1;
    ctl_we = 1'b0; set_we = 1'b0;
  endtask

  task automatic load(logic [2:0] si, logic [19:0] sd);
    @(negedge clk);
    set_we = 1'b1; set_idx = si; set_data = sd;
    @(posedge clk); #1;
    set_we = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200; i++) begin
      if (width_valid_o) break;
      @(negedge clk);
    end
  endtask

  function automatic int model_w(int x1, int x2, int hres);
    int s = x2 - x1;
    if (s <= 0 || s >= 2560) return hres;
    return (s * hres) / 2560;
  endfunction

  function automatic int model_h(int y1, int y2, bit dbl, int vres);
    int s = y2 - y1;
    if (dbl) s = s * 2;
    return (s <= 0) ? vres : s;
  endfunction

  int hres_m = 256;
  int vres_m = 240;
  bit dbl_m = 0;

  task automatic hspan(string req, int x1, int x2);
    int w = model_w(x1, x2, hres_m);
    int s = x2 - x1;
    ctl({8'h06, 12'(x2), 12'(x1)});
    if (s > 0 && s < 2560) begin
      expect_v(req, 8, 0);
      @(negedge clk);
      wait_valid();
    end
    expect_v(req, 4, 32'(w));
    expect_v(req, 8, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_v("R1", 0, 32'h1480_2000);
    expect_v("R1", 1, 0);
    expect_v("R1", 4, 256);
    expect_v("R1", 5, 240);
    expect_v("R1", 6, 256);
    expect_v("R1", 7, 240);
    expect_v("R1", 8, 1);
    // R2 blanking then direction
    ctl(32'h0300_0000);
    expect_v("R2", 0, 32'h1400_2000);
    ctl(32'h0400_0002);
    expect_v("R2", 0, 32'h5400_2000);
    // R3 display start
    ctl({8'h05, 4'h0, 10'h2AA, 10'h155});
    expect_v("R3", 2, 32'h155);
    expect_v("R3", 3, 32'h2AA);
    // R4 spans: full at 2560, scaled near edge, scaled mid, negative
    hspan("R4", 600, 3160);
    hspan("R4", 500, 3059);
    hspan("R4", 600, 1880);
    hspan("R4", 800, 700);
    // R5 height plain and fallback
    ctl({8'h07, 4'h0, 10'd256, 10'd16});
    expect_v("R5", 5, 32'(model_h(16, 256, 0, 240)));
    ctl({8'h07, 4'h0, 10'd100, 10'd300});
    expect_v("R5", 5, 240);
    ctl({8'h07, 4'h0, 10'd256, 10'd16});
    expect_v("R5", 5, 240);
    // R6 mode: width idx {3,1}=7 -> 640, double height, height idx 1 -> 480
    ctl(32'h0800_0047);
    hres_m = 640; vres_m = 480; dbl_m = 1;
    expect_v("R6", 0, 32'h540F_2000);
    expect_v("R6", 6, 640);
    expect_v("R6", 7, 480);
    expect_v("R6", 5, 32'(model_h(16, 256, dbl_m, vres_m)));
    expect_v("R6", 4, 640);
    hspan("R4", 600, 1880);
    // R8 identical range write must not restart the divider
    ctl({8'h06, 12'd1880, 12'd600});
    expect_v("R8", 8, 1);
    expect_v("R8", 4, 320);
    // R5 negative span doubled falls back
    ctl({8'h07, 4'h0, 10'd100, 10'd300});
    expect_v("R5", 5, 480);
    // R10 restart while busy
    ctl({8'h06, 12'd2000, 12'd0});
    expect_v("R10", 8, 0);
    @(negedge clk);
    ctl({8'h06, 12'd1000, 12'd0});
    expect_v("R10", 8, 0);
    @(negedge clk);
    wait_valid();
    expect_v("R10", 4, 32'(model_w(0, 1000, 640)));
    expect_v("R10", 8, 1);
    // R7 queries
    load(3'd2, 20'hDE123);
    load(3'd5, 20'h45678);
    ctl(32'h1000_0002); expect_v("R7", 1, 32'h000D_E123);
    ctl(32'h1000_0005); expect_v("R7", 1, 32'h0004_5678);
    ctl(32'h1000_0006); expect_v("R7", 1, 32'h0004_5678);
    ctl(32'h1000_0007); expect_v("R7", 1, 2);
    ctl(32'h1000_0000); expect_v("R7", 1, 0);
    ctl(32'h1F00_0007); expect_v("R7", 1, 2);
    ctl(32'h1000_0009); expect_v("R7", 1, 0);
    // R9 query and load on one edge
    load(3'd3, 20'hFFFFF);
    ctl(32'h1000_0003, 1, 3'd3, 20'h11111);
    expect_v("R9", 1, 32'h000F_FFFF);
    ctl(32'h1000_0003);
    expect_v("R9", 1, 32'h0001_1111);
    // R1/R8 reset command with data equal to its held copy
    ctl(32'h0000_0000);
    expect_v("R1", 0, 32'h1480_2000);
    expect_v("R1", 1, 0);
    expect_v("R1", 4, 256);
    expect_v("R1", 5, 240);
    expect_v("R1", 6, 256);
    expect_v("R1", 8, 1);
    // R11 commands with no function
    ctl(32'h1000_0007);
    ctl(32'h2000_0123);
    ctl(32'h0900_0055);
    expect_v("R11", 0, 32'h1480_2000);
    expect_v("R11", 1, 2);
    expect_v("R11", 4, 256);
    expect_v("R11", 5, 240);
    repeat (3) @(negedge clk);
    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule